// File: doc/BRIEF.md
# RISC Integer ALU with Overflow Trap

This block is the integer execution unit of a load-store RISC core. It is purely combinational. It takes two 32-bit operands, a 5-bit shift amount, a 4-bit operation code and a trap-enable flag. It returns a 32-bit result, an overflow exception strobe and a destination write enable.

The block covers these operations:
- add and subtract, each in a trapping (signed) form and a wrapping (unsigned) form;
- the bitwise AND, OR, XOR and NOR;
- a left shift and two right shifts, one logical and one arithmetic;
- the load-upper-immediate placement.

For register-immediate forms, the caller sign-extends the 16-bit immediate before presenting it on the second operand. Decoding, register access and exception vectoring are left to the surrounding core.

Top module: `risc_int_alu`

## Requirements
- R1: With `alu_op` = 0 (add), `result` equals `op_a + op_b` modulo 2^32. With `alu_op` = 1 (subtract), `result` equals `op_a - op_b` modulo 2^32. Both hold whatever `trap_en` is, including when overflow is flagged.
- R2: With `alu_op` = 0 and `trap_en` = 1, `ovf_trap` is 1 exactly when the two's-complement sum of the operands falls outside [-2^31, 2^31-1].
- R3: With `alu_op` = 1 and `trap_en` = 1, `ovf_trap` is 1 exactly when the two's-complement difference `op_a - op_b` falls outside [-2^31, 2^31-1].
- R4: With `trap_en` = 0, `ovf_trap` is never asserted. Add and subtract then simply wrap.
- R5: `wr_en` is 0 whenever `ovf_trap` is 1, and 1 otherwise.
- R6: Codes 2, 3, 4 and 5 give the bitwise AND, OR, XOR and NOR of `op_a` and `op_b`, and never trap.
- R7: Code 6 shifts `op_b` left by `shamt` and fills with zeros.
- R8: Code 7 shifts `op_b` right by `shamt` and fills with zeros.
- R9: Code 8 shifts `op_b` right by `shamt` and fills with copies of `op_b[31]`.
- R10: Code 9 (load upper immediate) gives `{op_b[15:0], 16'h0000}`.
- R11: Codes 10 to 15 give a zero result, `ovf_trap` = 0 and `wr_en` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand (register source) |
| op_b | input | 32 | Second operand (register or sign-extended immediate) |
| shamt | input | 5 | Shift distance |
| alu_op | input | 4 | Operation code, see requirements |
| trap_en | input | 1 | 1 selects the trapping signed add/subtract variant |
| result | output | 32 | Operation result |
| ovf_trap | output | 1 | Signed overflow exception strobe |
| wr_en | output | 1 | Destination write enable, dropped on overflow |

## Verification
The interaction of interest is when wrapping arithmetic and the overflow exception fall on the same vector. Once `ovf_trap` rises, `result` must still carry the wrapped sum or difference, and `wr_en` must drop in the same evaluation. The bench provokes this with operand pairs on the signed boundaries, such as 0x7FFFFFFF + 1 and 0x80000000 - 1. It runs each pair with `trap_en` at both values. A behavioural 64-bit signed reference judges the result, the strobe and the enable together on every clock.

// File: rtl/rialu_pkg.sv
package rialu_pkg;
  localparam int XLEN = 32;
  localparam int SHW  = $clog2(XLEN);
  localparam int OPW  = 4;
  localparam int IMMW = 16;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_NOR = 4'd5,
    OP_SLL = 4'd6,
    OP_SRL = 4'd7,
    OP_SRA = 4'd8,
    OP_LUI = 4'd9
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logic_sel_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2
  } shift_kind_e;

  // Signed overflow of an addition: the addends agree in sign and the sum disagrees.
  function automatic logic sign_overflow(input logic sa, input logic sb, input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction
endpackage

// File: rtl/rialu_addsub.sv
module rialu_addsub #(
  parameter int W = rialu_pkg::XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf_raw
);
  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  assign b_eff   = sub ? ~b : b;
  assign wide    = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
  assign sum     = wide[W-1:0];
  assign ovf_raw = rialu_pkg::sign_overflow(a[W-1], b_eff[W-1], sum[W-1]);

  always_comb begin
    // R1
    sum_inverse_chk: assert (sub ? ((sum + b) == a) : ((sum - b) == a))
      else $error("adder sum does not invert");
  end
endmodule

// File: rtl/rialu_logic.sv
module rialu_logic #(
  parameter int W = rialu_pkg::XLEN
) (
  input  logic [W-1:0]             a,
  input  logic [W-1:0]             b,
  input  rialu_pkg::logic_sel_e    sel,
  output logic [W-1:0]             res
);
  import rialu_pkg::*;

  always_comb begin
    unique case (sel)
      LG_AND:  res = a & b;
      LG_OR:   res = a | b;
      LG_XOR:  res = a ^ b;
      LG_NOR:  res = ~(a | b);
      default: res = '0;
    endcase
  end

  always_comb begin
    // R6
    nor_disjoint_chk: assert (sel != LG_NOR || ((res & (a | b)) == '0))
      else $error("nor result overlaps an operand bit");
  end
endmodule

// File: rtl/rialu_shift.sv
module rialu_shift #(
  parameter int W   = rialu_pkg::XLEN,
  parameter int SHW = rialu_pkg::SHW
) (
  input  logic [W-1:0]            val,
  input  logic [SHW-1:0]          amt,
  input  rialu_pkg::shift_kind_e  kind,
  output logic [W-1:0]            res
);
  import rialu_pkg::*;

  logic [W-1:0] stg [SHW+1];
  logic [W-1:0] fill;
  logic         go_left;

  assign go_left = (kind == SH_LEFT);
  assign fill    = (kind == SH_RARI && val[W-1]) ? {W{1'b1}} : '0;
  assign stg[0]  = val;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int D = 1 << k;
    assign stg[k+1] = !amt[k] ? stg[k] :
                      go_left ? (stg[k] << D) :
                      ((stg[k] >> D) | (fill << (W - D)));
  end

  assign res = stg[SHW];

  always_comb begin
    // R7
    zero_shift_chk: assert (amt != '0 || res == val)
      else $error("zero-distance shift altered the value");
    // R9
    arith_sign_chk: assert (kind != SH_RARI || res[W-1] == val[W-1])
      else $error("arithmetic shift lost the sign");
  end
endmodule

// File: rtl/risc_int_alu.sv
module risc_int_alu (
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic [4:0]  shamt,
  input  logic [3:0]  alu_op,
  input  logic        trap_en,
  output logic [31:0] result,
  output logic        ovf_trap,
  output logic        wr_en
);
  import rialu_pkg::*;

  localparam int W = XLEN;

  logic [W-1:0] arith_res, logic_res, shift_res, upper_res;
  logic         arith_ovf;
  logic         is_arith, is_logic, is_shift, is_upper;
  logic_sel_e   lsel;
  shift_kind_e  skind;

  assign is_arith = (alu_op == OP_ADD) || (alu_op == OP_SUB);
  assign is_logic = (alu_op >= OP_AND) && (alu_op <= OP_NOR);
  assign is_shift = (alu_op >= OP_SLL) && (alu_op <= OP_SRA);
  assign is_upper = (alu_op == OP_LUI);
  assign lsel     = logic_sel_e'(alu_op[1:0] - 2'd2);
  assign skind    = (alu_op == OP_SLL) ? SH_LEFT :
                    (alu_op == OP_SRL) ? SH_RLOG : SH_RARI;

  rialu_addsub #(.W(W)) u_addsub (
    .a(op_a), .b(op_b), .sub(alu_op == OP_SUB),
    .sum(arith_res), .ovf_raw(arith_ovf)
  );

  rialu_logic #(.W(W)) u_logic (
    .a(op_a), .b(op_b), .sel(lsel), .res(logic_res)
  );

  rialu_shift #(.W(W), .SHW(SHW)) u_shift (
    .val(op_b), .amt(shamt), .kind(skind), .res(shift_res)
  );

  assign upper_res = {op_b[IMMW-1:0], {(W-IMMW){1'b0}}};

  always_comb begin
    if (is_arith)      result = arith_res;
    else if (is_logic) result = logic_res;
    else if (is_shift) result = shift_res;
    else if (is_upper) result = upper_res;
    else               result = '0;
  end

  assign ovf_trap = trap_en && is_arith && arith_ovf;
  assign wr_en    = !ovf_trap;

  always_comb begin
    // R4
    no_overflow_chk: assert (trap_en || !ovf_trap)
      else $error("trap raised on wrapping variant");
    // R2
    trap_source_chk: assert (!ovf_trap || is_arith)
      else $error("trap raised by a non-arithmetic operation");
    // R10
    upper_low_zero_chk: assert (!is_upper || result[15:0] == 16'h0)
      else $error("upper placement left low bits set");
    // R11
    unused_code_chk: assert (is_arith || is_logic || is_shift || is_upper || result == '0)
      else $error("unused code produced nonzero result");
  end
endmodule

// File: tb/risc_int_alu_test.sv
module risc_int_alu_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op_a = '0, op_b = '0;
  logic [4:0]  shamt = '0;
  logic [3:0]  alu_op = '0;
  logic        trap_en = 1'b0;
  logic [31:0] result;
  logic        ovf_trap, wr_en;

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #(PERIOD/2) clk = ~clk;

  risc_int_alu uut (
    .op_a(op_a), .op_b(op_b), .shamt(shamt), .alu_op(alu_op),
    .trap_en(trap_en), .result(result), .ovf_trap(ovf_trap), .wr_en(wr_en)
  );

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(input string req, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] sh, input logic te);
    longint      full;
    logic [31:0] exp_r;
    logic        exp_o;
    @(negedge clk);
    op_a = a; op_b = b; shamt = sh; alu_op = op; trap_en = te;
    exp_o = 1'b0;
    case (op)
      4'd0: begin
        exp_r = a + b;
        full  = longint'($signed(a)) + longint'($signed(b));
        exp_o = te && (full > 64'sd2147483647 || full < -64'sd2147483648);
      end
      4'd1: begin
        exp_r = a - b;
        full  = longint'($signed(a)) - longint'($signed(b));
        exp_o = te && (full > 64'sd2147483647 || full < -64'sd2147483648);
      end
      4'd2: exp_r = a & b;
      4'd3: exp_r = a | b;
      4'd4: exp_r = a ^ b;
      4'd5: exp_r = ~(a | b);
      4'd6: exp_r = b << sh;
      4'd7: exp_r = b >> sh;
      4'd8: exp_r = $unsigned($signed(b) >>> sh);
      4'd9: exp_r = {b[15:0], 16'h0};
      default: exp_r = 32'h0;
    endcase
    #(PERIOD/4);
    checks++;
    if (result !== exp_r || ovf_trap !== exp_o || wr_en !== !exp_o) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h sh=%0d te=%0b: got r=%h o=%0b w=%0b exp r=%h o=%0b w=%0b",
               req, op, a, b, sh, te, result, ovf_trap, wr_en, exp_r, exp_o, !exp_o);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: all inputs zero
    check("R1", 4'd0, 32'h0, 32'h0, 5'd0, 1'b0);
    // R1 wrapping add/sub
    check("R1", 4'd0, 32'hFFFF_FFFF, 32'h2, 5'd0, 1'b0);
    check("R1", 4'd1, 32'h0, 32'h1, 5'd0, 1'b1);
    // R2 add overflow boundaries, R5 enable drop, R4 same with trap off
    check("R2", 4'd0, 32'h7FFF_FFFF, 32'h1, 5'd0, 1'b1);
    check("R2", 4'd0, 32'h8000_0000, 32'h8000_0000, 5'd0, 1'b1);
    check("R2", 4'd0, 32'h7FFF_FFFE, 32'h1, 5'd0, 1'b1);
    check("R5", 4'd0, 32'h4000_0000, 32'h4000_0000, 5'd0, 1'b1);
    check("R4", 4'd0, 32'h7FFF_FFFF, 32'h1, 5'd0, 1'b0);
    // R3 subtract overflow boundaries
    check("R3", 4'd1, 32'h8000_0000, 32'h1, 5'd0, 1'b1);
    check("R3", 4'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0, 1'b1);
    check("R3", 4'd1, 32'h0, 32'h8000_0000, 5'd0, 1'b1);
    check("R3", 4'd1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 5'd0, 1'b1);
    check("R4", 4'd1, 32'h8000_0000, 32'h1, 5'd0, 1'b0);
    // R6 logic, including NOR with trap on
    check("R6", 4'd2, 32'hF0F0_1234, 32'h0FF0_FFFF, 5'd0, 1'b1);
    check("R6", 4'd3, 32'hF0F0_1234, 32'h0FF0_0000, 5'd0, 1'b0);
    check("R6", 4'd4, 32'hAAAA_5555, 32'hFFFF_0000, 5'd0, 1'b0);
    check("R6", 4'd5, 32'h0000_0000, 32'h0000_0000, 5'd0, 1'b1);
    // R7 R8 R9 shifts at boundaries
    check("R7", 4'd6, 32'h0, 32'h8000_0001, 5'd31, 1'b0);
    check("R7", 4'd6, 32'h0, 32'h1234_5678, 5'd0, 1'b0);
    check("R8", 4'd7, 32'h0, 32'h8000_0000, 5'd31, 1'b0);
    check("R8", 4'd7, 32'h0, 32'hF000_000F, 5'd4, 1'b0);
    check("R9", 4'd8, 32'h0, 32'h8000_0000, 5'd31, 1'b0);
    check("R9", 4'd8, 32'h0, 32'h7000_0000, 5'd4, 1'b0);
    check("R9", 4'd8, 32'h0, 32'hF000_0010, 5'd4, 1'b1);
    // R10 upper placement ignores high half of op_b
    check("R10", 4'd9, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 5'd7, 1'b1);
    // R11 unused codes
    for (int c = 10; c < 16; c++)
      check("R11", 4'(c), 32'h7FFF_FFFF, 32'h1, 5'd3, 1'b1);
    // mixed pseudo-random sweep over all codes
    for (int i = 0; i < 600; i++) begin
      logic [31:0] ra, rb, rc;
      seed = next_rand(seed); ra = seed;
      seed = next_rand(seed); rb = seed;
      seed = next_rand(seed); rc = seed;
      if (rc[8]) rb = {ra[31], rb[30:0]};
      check("R1", rc[3:0], ra, rb, rc[8:4], rc[9]);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule